// File: doc/BRIEF.md
# Modulator Configuration Startup Sequencer

This block brings an external quadrature upconverter out of reset and into continuous modulation in a safe order. It pulses the device reset line, programs the reference clock multiplier over a serial control port, waits a programmable interval for the multiplier loop to lock, and only then writes the continuous-modulation mode. When that last write is acknowledged, it raises a data-enable output that lets the sample-streaming logic send nonzero samples. Until then the sample path stays gated and sends only zeros.

The serial shifter sits outside this block and is driven through a start / busy / done handshake. An overflow or fault input from the datapath makes the block restart from the device reset. A rewrite of the mode alone cannot clear a corrupted interpolator, so no other recovery path exists. A status output gives the current phase. A sticky flag records that a fault ever occurred, and a host clear input resets that flag.

Top module: `mod_startup_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `state_out` is 0 (device-reset phase), `dev_reset` is 1, and `data_en`, `spi_start` and `fault_seen` are 0.
- R2: `dev_reset` stays high for exactly `RST_CYCLES` cycles (at least 8; smaller values are raised to 8), counted after reset release or after the fault phase. The phase then moves to 1 (multiplier write).
- R3: The multiplier write is a one-cycle `spi_start` carrying `spi_word` = {8'h01, 1'b1, 2'b00, factor[4:0]}, which is 16'h0184 for the default factor 4. The continuous-mode write carries {8'h00, 8'h01}. No word sets both enables.
- R4: In a write phase, `spi_start` is raised only while `spi_busy` is low. The phase advances on the cycle after `spi_done` is sampled high.
- R5: After the multiplier write is acknowledged, the block stays in phase 2 (lock wait) for exactly CLK_FREQ_HZ/1000 + CLK_FREQ_HZ/10000 cycles, then enters phase 3 (continuous write).
- R6: `data_en` is 1 only in phase 4 (running), which is entered only after the continuous-mode write is acknowledged.
- R7: `fault_in` high in phases 1 to 4 moves the block to phase 5 (fault) on the next cycle, and fault takes priority over `spi_done`. Phase 5 lasts one cycle and is followed by phase 0. `fault_in` has no effect in phases 0 and 5.
- R8: If `spi_busy` stays high for `SPI_TIMEOUT` cycles before a start can be issued, or if `spi_done` does not arrive within `SPI_TIMEOUT` cycles after the start, the block enters phase 5.
- R9: `fault_seen` is set on the edge that enters phase 5 and cleared by `sticky_clr`. When both fall in the same cycle, the set wins.
- R10: `state_out` codes are 0 reset pulse, 1 multiplier write, 2 lock wait, 3 continuous write, 4 running and 5 fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_busy | input | 1 | Serial shifter is occupied |
| spi_done | input | 1 | Serial write finished (one-cycle pulse) |
| spi_start | output | 1 | Launch one serial write |
| spi_word | output | 16 | Address byte and data byte for the write |
| dev_reset | output | 1 | Hardware reset to the upconverter |
| data_en | output | 1 | Lets the sample path send nonzero data |
| fault_in | input | 1 | Overflow or fault report from the datapath |
| sticky_clr | input | 1 | Host clear of the sticky fault flag |
| state_out | output | 3 | Current phase code |
| fault_seen | output | 1 | Sticky record that a fault occurred |

## Verification
Two events can land in the same cycle: a fault that sets the sticky flag and a host clear that resets it. The bench raises `sticky_clr` and `fault_in` together while the block is running and expects `fault_seen` to read 1 one cycle later. A second clear on its own must then bring the flag to 0. The bench also lets a fault arrive while a write waits for its acknowledge. The behavioural model, advanced on every edge, decides whether fault or done wins.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_MULT  = 3'd1,
        ST_LOCK  = 3'd2,
        ST_CONT  = 3'd3,
        ST_RUN   = 3'd4,
        ST_FAULT = 3'd5
    } seq_state_e;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int WORD_W = ADDR_W + DATA_W;
    localparam int MIN_RST_CYCLES = 8;

    localparam logic [ADDR_W-1:0] MULT_ADDR = 8'h01;
    localparam logic [ADDR_W-1:0] CONT_ADDR = 8'h00;

    // multiplier enable in bit 7, factor in bits 4:0, mode bit clear
    function automatic logic [WORD_W-1:0] mult_word(input int unsigned factor);
        logic [4:0] f;
        f = factor[4:0];
        return {MULT_ADDR, 1'b1, 2'b00, f};
    endfunction

    // continuous-mode enable in bit 0 of its own register
    function automatic logic [WORD_W-1:0] cont_word();
        return {CONT_ADDR, 8'h01};
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/mseq_timer.sv
module mseq_timer #(
    parameter int CNT_W     = 8,
    parameter int RESET_VAL = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_W'(RESET_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign cnt_zero = (cnt == '0);
endmodule

// File: rtl/mseq_flag.sv
module mseq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_evt)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
    import mseq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int RST_CYCLES  = 8,
    parameter int LOCK_CYCLES = 8,
    parameter int SPI_TIMEOUT = 8,
    parameter int MULT_FACTOR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_busy,
    input  logic              spi_done,
    input  logic              fault_in,
    input  logic              cnt_zero,
    output seq_state_e        state,
    output logic              spi_start,
    output logic [WORD_W-1:0] spi_word,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              fault_enter
);
    localparam logic [CNT_W-1:0] RST_LOAD  = CNT_W'(RST_CYCLES - 1);
    localparam logic [CNT_W-1:0] LOCK_LOAD = CNT_W'(LOCK_CYCLES - 1);
    localparam logic [CNT_W-1:0] TO_LOAD   = CNT_W'(SPI_TIMEOUT - 1);

    seq_state_e nxt;
    logic       issued, issued_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_RESET;
            issued <= 1'b0;
        end else begin
            state  <= nxt;
            issued <= issued_n;
        end
    end

    always_comb begin
        nxt       = state;
        issued_n  = issued;
        load      = 1'b0;
        load_val  = '0;
        spi_start = 1'b0;
        spi_word  = (state == ST_CONT) ? cont_word() : mult_word(MULT_FACTOR);
        unique case (state)
            ST_RESET: begin
                if (cnt_zero) begin
                    nxt      = ST_MULT;
                    issued_n = 1'b0;
                    load     = 1'b1;
                    load_val = TO_LOAD;
                end
            end
            ST_MULT, ST_CONT: begin
                if (fault_in) begin
                    nxt = ST_FAULT;
                end else if (!issued) begin
                    if (!spi_busy) begin
                        spi_start = 1'b1;
                        issued_n  = 1'b1;
                        load      = 1'b1;
                        load_val  = TO_LOAD;
                    end else if (cnt_zero) begin
                        nxt = ST_FAULT;
                    end
                end else if (spi_done) begin
                    issued_n = 1'b0;
                    if (state == ST_MULT) begin
                        nxt      = ST_LOCK;
                        load     = 1'b1;
                        load_val = LOCK_LOAD;
                    end else begin
                        nxt = ST_RUN;
                    end
                end else if (cnt_zero) begin
                    nxt = ST_FAULT;
                end
            end
            ST_LOCK: begin
                if (fault_in) begin
                    nxt = ST_FAULT;
                end else if (cnt_zero) begin
                    nxt      = ST_CONT;
                    issued_n = 1'b0;
                    load     = 1'b1;
                    load_val = TO_LOAD;
                end
            end
            ST_RUN: begin
                if (fault_in) nxt = ST_FAULT;
            end
            ST_FAULT: begin
                nxt      = ST_RESET;
                load     = 1'b1;
                load_val = RST_LOAD;
            end
            default: nxt = ST_RESET;
        endcase
    end

    assign fault_enter = (nxt == ST_FAULT) && (state != ST_FAULT);
endmodule

// File: rtl/mod_startup_seq.sv
module mod_startup_seq
    import mseq_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 125_000_000,
    parameter int RST_CYCLES  = 8,
    parameter int SPI_TIMEOUT = 4096,
    parameter int MULT_FACTOR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_busy,
    input  logic              spi_done,
    output logic              spi_start,
    output logic [WORD_W-1:0] spi_word,
    output logic              dev_reset,
    output logic              data_en,
    input  logic              fault_in,
    input  logic              sticky_clr,
    output logic [2:0]        state_out,
    output logic              fault_seen
);
    localparam int RST_EFF     = (RST_CYCLES < MIN_RST_CYCLES) ? MIN_RST_CYCLES : RST_CYCLES;
    localparam int LOCK_CYCLES = CLK_FREQ_HZ / 1000 + CLK_FREQ_HZ / 10000;
    localparam int CNT_MAX     = int'(max3(RST_EFF, LOCK_CYCLES, SPI_TIMEOUT));
    localparam int CNT_W       = $clog2(CNT_MAX + 1);

    seq_state_e       state;
    logic             load, cnt_zero, fault_enter;
    logic [CNT_W-1:0] load_val;

    mseq_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (RST_EFF - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .cnt_zero (cnt_zero)
    );

    mseq_ctrl #(
        .CNT_W       (CNT_W),
        .RST_CYCLES  (RST_EFF),
        .LOCK_CYCLES (LOCK_CYCLES),
        .SPI_TIMEOUT (SPI_TIMEOUT),
        .MULT_FACTOR (MULT_FACTOR)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .spi_busy    (spi_busy),
        .spi_done    (spi_done),
        .fault_in    (fault_in),
        .cnt_zero    (cnt_zero),
        .state       (state),
        .spi_start   (spi_start),
        .spi_word    (spi_word),
        .load        (load),
        .load_val    (load_val),
        .fault_enter (fault_enter)
    );

    mseq_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (fault_enter),
        .clr     (sticky_clr),
        .flag    (fault_seen)
    );

    assign dev_reset = (state == ST_RESET);
    assign data_en   = (state == ST_RUN);
    assign state_out = state;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk (
    input logic        clk,
    input logic        rst,
    input logic        spi_start,
    input logic [15:0] spi_word,
    input logic        spi_busy,
    input logic        dev_reset,
    input logic        data_en,
    input logic        fault_in,
    input logic        sticky_clr,
    input logic [2:0]  state_out,
    input logic        fault_seen
);
    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (state_out == 3'd0 && !fault_seen));

    // R3
    start_word_chk: assert property (@(posedge clk) disable iff (rst)
        spi_start |-> ((state_out == 3'd1 && spi_word[15:8] == 8'h01 && spi_word[0] == 1'b0) ||
                       (state_out == 3'd3 && spi_word == 16'h0001)));

    // R4
    start_idle_chk: assert property (@(posedge clk) disable iff (rst) spi_start |-> !spi_busy);

    // R6
    data_en_run_chk: assert property (@(posedge clk) disable iff (rst) data_en |-> state_out == 3'd4);

    // R6
    run_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_en) |-> $past(state_out) == 3'd3);

    // R5
    lock_order_chk: assert property (@(posedge clk) disable iff (rst)
        state_out == 3'd2 |=> state_out inside {3'd2, 3'd3, 3'd5});

    // R7
    fault_exit_chk: assert property (@(posedge clk) disable iff (rst)
        state_out == 3'd5 |=> (state_out == 3'd0 && dev_reset));

    // R7
    run_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (state_out == 3'd4 && fault_in) |=> state_out == 3'd5);

    // R9
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst) state_out == 3'd5 |-> fault_seen);

    // R9
    sticky_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (sticky_clr && state_out != 3'd5 && !(fault_in && state_out inside {3'd1, 3'd2, 3'd3, 3'd4}))
        |=> (!fault_seen || state_out == 3'd5));
endmodule

bind mod_startup_seq mseq_chk u_chk (.*);

// File: tb/mod_startup_seq_tb.sv
module mod_startup_seq_tb;
    localparam int CLK_HZ = 20000;
    localparam int RSTC   = 10;
    localparam int TO     = 16;
    localparam int LOCK   = CLK_HZ / 1000 + CLK_HZ / 10000;

    logic clk = 0, rst = 1, spi_busy = 0, spi_done = 0, fault_in = 0, sticky_clr = 0;
    logic spi_start, dev_reset, data_en, fault_seen;
    logic [15:0] spi_word;
    logic [2:0] state_out;

    int checks = 0, errors = 0, cyc = 0;
    bit started = 0;

    // SPI responder: 0 normal, 1 never done, 2 always busy
    int resp_mode = 0, resp_delay = 3, resp_cnt = 0;
    logic saw_start = 0;

    // behavioural model
    int m_state = 0, m_el = 0, m_seen = 0;
    bit m_iss = 0;

    always #4 clk = ~clk;

    mod_startup_seq #(.CLK_FREQ_HZ(CLK_HZ), .RST_CYCLES(RSTC), .SPI_TIMEOUT(TO), .MULT_FACTOR(4)) u_dut (
        .clk(clk), .rst(rst), .spi_busy(spi_busy), .spi_done(spi_done), .spi_start(spi_start),
        .spi_word(spi_word), .dev_reset(dev_reset), .data_en(data_en), .fault_in(fault_in),
        .sticky_clr(sticky_clr), .state_out(state_out), .fault_seen(fault_seen));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        saw_start <= spi_start;
        started = 1;
        if (rst) begin
            m_state = 0; m_el = 0; m_iss = 0; m_seen = 0;
        end else begin
            int nx;
            bit fg;
            nx = m_state;
            fg = fault_in && (m_state >= 1 && m_state <= 4);
            case (m_state)
                0: if (m_el == RSTC - 1) begin nx = 1; m_el = 0; m_iss = 0; end else m_el++;
                1, 3: begin
                    if (fg) nx = 5;
                    else if (!m_iss) begin
                        if (!spi_busy) begin m_iss = 1; m_el = 0; end
                        else if (m_el == TO - 1) nx = 5;
                        else m_el++;
                    end else if (spi_done) begin
                        nx = (m_state == 1) ? 2 : 4; m_el = 0; m_iss = 0;
                    end else if (m_el == TO - 1) nx = 5;
                    else m_el++;
                end
                2: if (fg) nx = 5; else if (m_el == LOCK - 1) begin nx = 3; m_el = 0; m_iss = 0; end else m_el++;
                4: if (fg) nx = 5;
                5: begin nx = 0; m_el = 0; end
                default: nx = 0;
            endcase
            if (nx == 5 && m_state != 5) m_seen = 1;
            else if (sticky_clr) m_seen = 0;
            m_state = nx;
        end
    end

    // responder
    always @(negedge clk) begin
        spi_done = 0;
        if (resp_mode == 2) spi_busy = 1;
        else if (saw_start) begin
            if (resp_mode == 1) begin spi_busy = 1; resp_cnt = -1; end
            else resp_cnt = resp_delay;
        end
        if (resp_mode == 0 && resp_cnt > 0) begin
            spi_busy = 1;
            resp_cnt--;
            if (resp_cnt == 0) begin spi_busy = 0; spi_done = 1; end
        end else if (resp_mode == 0 && resp_cnt == 0) spi_busy = 0;
    end

    // per-cycle compare against the model
    always @(negedge clk) begin
        #1;
        if (started) begin
            bit e_start;
            e_start = (m_state == 1 || m_state == 3) && !m_iss && !spi_busy;
            check(state_out == 3'(m_state), "R10 state", state_out, m_state);
            check(dev_reset == (m_state == 0), "R2 dev_reset", dev_reset, m_state == 0);
            check(data_en == (m_state == 4), "R6 data_en", data_en, m_state == 4);
            check(spi_start == e_start, "R4 spi_start", spi_start, e_start);
            if (e_start)
                check(spi_word == ((m_state == 3) ? 16'h0001 : 16'h0184), "R3 spi_word",
                      spi_word, (m_state == 3) ? 16'h0001 : 16'h0184);
            check(fault_seen == m_seen, "R9 fault_seen", fault_seen, m_seen);
        end
    end

    task automatic wait_state(input int code, input int limit, input string tag);
        int n = 0;
        while (state_out != 3'(code) && n < limit) begin @(negedge clk); #2; n++; end
        check(state_out == 3'(code), tag, state_out, code);
    endtask

    task automatic pulse_fault(input bit with_clr);
        @(negedge clk); fault_in = 1; sticky_clr = with_clr;
        @(negedge clk); fault_in = 0; sticky_clr = 0;
    endtask

    // watchdog
    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired, actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0, tc;
        repeat (3) @(negedge clk);
        #2;
        // R1
        check(state_out == 3'd0 && dev_reset && !data_en && !spi_start && !fault_seen,
              "R1 reset state", state_out, 0);
        @(negedge clk); rst = 0;
        t0 = cyc;
        #2;
        check(dev_reset == 1'b1, "R1 first cycle", dev_reset, 1);
        wait_state(3, 400, "R5 continuous write reached");
        tc = cyc;
        check(tc - t0 >= RSTC + LOCK, "R5 lock wait length", tc - t0, RSTC + LOCK);
        wait_state(4, 400, "R6 running reached");
        check(data_en == 1'b1, "R6 data enabled", data_en, 1);
        repeat (5) @(negedge clk);
        // R7 fault in run restarts from device reset
        pulse_fault(0);
        #2;
        check(state_out == 3'd5, "R7 fault phase", state_out, 5);
        @(negedge clk); #2;
        check(state_out == 3'd0 && dev_reset, "R7 back to reset", state_out, 0);
        // fault during reset pulse is ignored
        pulse_fault(0);
        #2;
        check(state_out == 3'd0, "R7 ignored in reset", state_out, 0);
        wait_state(4, 400, "R7 running again");
        @(negedge clk); sticky_clr = 1; @(negedge clk); sticky_clr = 0; #2;
        check(fault_seen == 1'b0, "R9 cleared", fault_seen, 0);
        // R9 set and clear in the same cycle
        pulse_fault(1);
        #2;
        check(fault_seen == 1'b1, "R9 set wins", fault_seen, 1);
        @(negedge clk); sticky_clr = 1; @(negedge clk); sticky_clr = 0; #2;
        check(fault_seen == 1'b0, "R9 clear alone", fault_seen, 0);
        // fault during lock wait
        wait_state(2, 400, "R7 lock wait");
        repeat (3) @(negedge clk);
        pulse_fault(0);
        #2;
        check(state_out == 3'd5, "R7 fault in lock", state_out, 5);
        // R8 never done
        resp_mode = 1;
        wait_state(5, 400, "R8 done timeout");
        resp_mode = 0; spi_busy = 0; resp_cnt = 0;
        wait_state(4, 400, "R8 recovery");
        // R8 always busy
        pulse_fault(0);
        resp_mode = 2;
        wait_state(1, 400, "R8 mult phase");
        wait_state(5, 400, "R8 busy timeout");
        resp_mode = 0; spi_busy = 0; resp_cnt = 0;
        // R4 slow acknowledge
        resp_delay = 7;
        wait_state(4, 600, "R4 slow acknowledge");
        // fault while a write waits for done
        pulse_fault(0);
        wait_state(1, 400, "R7 mult phase");
        repeat (3) @(negedge clk);
        pulse_fault(0);
        #2;
        check(state_out == 3'd5, "R7 fault over pending done", state_out, 5);
        resp_delay = 2;
        wait_state(4, 400, "R6 final run");
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule